// File: doc/BRIEF.md
# MMC Host Register File and Interrupts

This block is the processor-facing register front end of a MultiMediaCard host controller. A simple bus with a valid, write flag, 12-bit byte address and 32-bit data reaches word-aligned registers. These registers hold the card power and clock settings, the command argument and command word, a data timeout, the transfer length, the data control byte and two interrupt masks. Read-only registers return the card response, the data engine's remaining byte count, the status word, a host word counter and a small identification area.

The command unit and the data engine sit beside this block and connect through internal ports. The command unit receives the command and argument together with a start strobe, and loads responses back. The data engine receives a start strobe, and it raises event bits and drives level-type status bits. It also owns the data FIFO. This block only forwards push and pop strobes through a 16-word aliased data window. A host word counter gates that window. The counter is loaded from the transfer length when a data transfer is started.

Sticky event bits and live level bits together form a 22-bit status word. Two interrupt lines each report whether any status bit enabled by that line's own mask is set. Accesses to an undefined offset, or in a direction the register does not support, do nothing and raise an error pulse.

Top module: `mmc_host_regs`

## Requirements
- R1: After reset, every register reads 0 except the clock register, which keeps its value. Both interrupt lines are low and the read data is 0.
- R2: Writes to the power register (0x00), clock register (0x04) and data control register (0x2C) keep bits 7:0. Writes to the length register (0x28) keep bits 15:0. The argument register (0x08) and data timer register (0x24) keep all 32 bits. The masks (0x3C for line 0, 0x40 for line 1) keep bits 21:0. Each register reads back what it kept.
- R3: A read accepted at one clock edge shows its data on bus_rdata from that edge on. The data holds until the next read.
- R4: A write to the clear register (0x38) clears each status bit 10:0 whose bit is set in the written value. Status bits 21:11 follow sts_live, registered, and the clear has no effect on them. A set and a clear of the same bit in the same cycle leave the bit set.
- R5: A one-cycle pulse on sts_set bit i sets status bit i, and the bit stays set until it is cleared.
- R6: irq[n] becomes 1 one cycle after (status AND mask n) becomes nonzero, and returns to 0 one cycle after it becomes zero.
- R7: A write to the command register (0x0C) with bit 10 set produces a one-cycle cmd_start pulse after the write edge. The register stores and reads back the written value with bit 10 cleared. Without bit 10 there is no pulse.
- R8: A write to data control with bit 0 set pulses data_start. The same write loads the host word count (read at 0x48) with (length+3)/4, using the length held before the write.
- R9: Any word offset 0x80 to 0xBC is the FIFO window. When the host word count is nonzero, a read pops one word: fifo_pop is high in the access cycle and the read returns fifo_rdata. A write pushes one word: fifo_push is high in the access cycle and fifo_wdata carries the bus data. Each such access decrements the count.
- R10: A FIFO window access while the host word count is 0 returns 0 on a read, strobes neither fifo_push nor fifo_pop, and leaves the count at 0.
- R11: Word offsets 0xFE0 to 0xFFC read the identification bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, in address order, in bits 7:0.
- R12: An access to an undefined offset, a misaligned address, a write to a read-only register or a read of the clear register changes no register. A read of this kind returns 0. bus_err pulses one cycle after the access edge.
- R13: resp_load latches resp_cmd at 0x10 and response words 0 to 3 at 0x14 to 0x20, with word i taken from resp_data[32i+31:32i]. Offset 0x30 reads data_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Pulse after an illegal access |
| pwr_ctl | output | 8 | Power register |
| clk_ctl | output | 8 | Clock register |
| cmd_arg | output | 32 | Command argument |
| cmd_word | output | 32 | Command register |
| cmd_start | output | 1 | Command start pulse |
| data_timer | output | 32 | Data timeout value |
| data_len | output | 16 | Transfer length in bytes |
| data_ctl | output | 8 | Data control register |
| data_start | output | 1 | Data transfer start pulse |
| fifo_push | output | 1 | Push strobe to the FIFO, access cycle |
| fifo_pop | output | 1 | Pop strobe to the FIFO, access cycle |
| fifo_wdata | output | 32 | Word to push |
| fifo_rdata | input | 32 | Head word of the FIFO |
| resp_load | input | 1 | Latch response |
| resp_cmd | input | 6 | Responding command index |
| resp_data | input | 128 | Four response words |
| data_count | input | 16 | Remaining bytes from data engine |
| sts_set | input | 11 | Sticky status event pulses |
| sts_live | input | 11 | Level status for bits 21:11 |
| irq | output | 2 | Masked interrupt lines |

## Verification
The bench drives each access at a falling edge and treats the next rising edge as the access edge. Register contents, bus_rdata, bus_err, cmd_start and data_start are sampled one time unit after that edge. The FIFO strobes are combinational, so the bench samples them before the access edge while the request is still held. The interrupt lines take one more register stage, so the bench waits a further rising edge after any status or mask change before it samples irq. Status bits 21:11 pass through a register, so the bench reads them only after an extra edge.

// File: rtl/mmc_regs_pkg.sv
package mmc_regs_pkg;
  localparam int ADDR_W = 12;
  localparam int NUM_IRQ = 2;
  localparam int CMD_GO_BIT = 10;
  localparam int DCTL_GO_BIT = 0;

  typedef enum logic [4:0] {
    RG_NONE, RG_PWR, RG_CLK, RG_ARG, RG_CMD, RG_RCMD, RG_RESP, RG_TMR,
    RG_LEN, RG_DCTL, RG_DCNT, RG_STAT, RG_CLR, RG_MSK, RG_FCNT, RG_FIFO, RG_ID
  } reg_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h81;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/mmc_addr_decode.sv
module mmc_addr_decode
  import mmc_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output reg_sel_e          sel,
  output logic              legal
);
  always_comb begin
    sel = RG_NONE;
    if (addr[1:0] == 2'b00) begin
      if (addr >= 12'hFE0) sel = RG_ID;
      else if (addr >= 12'h080 && addr <= 12'h0BC) sel = RG_FIFO;
      else begin
        case (addr)
          12'h000: sel = RG_PWR;
          12'h004: sel = RG_CLK;
          12'h008: sel = RG_ARG;
          12'h00C: sel = RG_CMD;
          12'h010: sel = RG_RCMD;
          12'h014, 12'h018, 12'h01C, 12'h020: sel = RG_RESP;
          12'h024: sel = RG_TMR;
          12'h028: sel = RG_LEN;
          12'h02C: sel = RG_DCTL;
          12'h030: sel = RG_DCNT;
          12'h034: sel = RG_STAT;
          12'h038: sel = RG_CLR;
          12'h03C, 12'h040: sel = RG_MSK;
          12'h048: sel = RG_FCNT;
          default: sel = RG_NONE;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      RG_NONE: legal = 1'b0;
      RG_CLR:  legal = is_write;
      RG_RCMD, RG_RESP, RG_DCNT, RG_STAT, RG_FCNT, RG_ID: legal = !is_write;
      default: legal = 1'b1;
    endcase
  end
endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq #(
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int NUM_IRQ  = 2,
  localparam int STS_W   = STICKY_W + LIVE_W
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [STICKY_W-1:0]             sts_set,
  input  logic [LIVE_W-1:0]               sts_live,
  input  logic                            clr_en,
  input  logic [STICKY_W-1:0]             clr_bits,
  input  logic [NUM_IRQ-1:0]              mask_we,
  input  logic [STS_W-1:0]                mask_wdata,
  output logic [STS_W-1:0]                status,
  output logic [NUM_IRQ-1:0][STS_W-1:0]   masks,
  output logic [NUM_IRQ-1:0]              irq
);
  logic [STICKY_W-1:0] sticky_q;
  logic [LIVE_W-1:0]   live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      live_q   <= '0;
    end else begin
      sticky_q <= (sticky_q & ~(clr_en ? clr_bits : '0)) | sts_set;
      live_q   <= sts_live;
    end
  end

  assign status = {live_q, sticky_q};

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [STS_W-1:0] mask_q;
    logic             irq_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        if (mask_we[g]) mask_q <= mask_wdata;
        irq_q <= |(status & mask_q);
      end
    end
    assign masks[g] = mask_q;
    assign irq[g]   = irq_q;
  end
endmodule

// File: rtl/mmc_fifo_gate.sv
module mmc_fifo_gate #(
  parameter int LEN_W = 16,
  localparam int CNT_W = LEN_W - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             access,
  output logic [CNT_W-1:0] cnt,
  output logic             open
);
  logic [LEN_W:0] len_up;
  assign len_up = {1'b0, len} + (LEN_W+1)'(3);
  assign open   = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (load)           cnt <= len_up[LEN_W:2];
    else if (access && open) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/mmc_host_regs.sv
module mmc_host_regs
  import mmc_regs_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int STICKY_W = 11,
  parameter int LIVE_W   = 11,
  parameter int DW       = 32,
  localparam int STS_W   = STICKY_W + LIVE_W,
  localparam int CNT_W   = LEN_W - 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic                bus_err,
  output logic [7:0]          pwr_ctl,
  output logic [7:0]          clk_ctl,
  output logic [DW-1:0]       cmd_arg,
  output logic [DW-1:0]       cmd_word,
  output logic                cmd_start,
  output logic [DW-1:0]       data_timer,
  output logic [LEN_W-1:0]    data_len,
  output logic [7:0]          data_ctl,
  output logic                data_start,
  output logic                fifo_push,
  output logic                fifo_pop,
  output logic [DW-1:0]       fifo_wdata,
  input  logic [DW-1:0]       fifo_rdata,
  input  logic                resp_load,
  input  logic [5:0]          resp_cmd,
  input  logic [4*DW-1:0]     resp_data,
  input  logic [LEN_W-1:0]    data_count,
  input  logic [STICKY_W-1:0] sts_set,
  input  logic [LIVE_W-1:0]   sts_live,
  output logic [NUM_IRQ-1:0]  irq
);
  reg_sel_e sel;
  logic     legal, wr, rd, fifo_acc, gate_open, dctl_go;
  logic [STS_W-1:0]              status_w;
  logic [NUM_IRQ-1:0][STS_W-1:0] mask_w;
  logic [NUM_IRQ-1:0]            mask_we;
  logic [CNT_W-1:0]              host_cnt;
  logic [DW-1:0]                 resp_q [4];
  logic [5:0]                    rcmd_q;
  logic [DW-1:0]                 rd_mux;
  logic [1:0]                    resp_idx;

  mmc_addr_decode u_dec (.addr(bus_addr), .is_write(bus_write), .sel(sel), .legal(legal));

  assign wr       = bus_valid && bus_write && legal;
  assign rd       = bus_valid && !bus_write && legal;
  assign fifo_acc = bus_valid && legal && (sel == RG_FIFO);
  assign dctl_go  = wr && (sel == RG_DCTL) && bus_wdata[DCTL_GO_BIT];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mwe
    assign mask_we[g] = wr && (sel == RG_MSK) && (bus_addr[6] == 1'(g));
  end

  mmc_status_irq #(.STICKY_W(STICKY_W), .LIVE_W(LIVE_W), .NUM_IRQ(NUM_IRQ)) u_sts (
    .clk(clk), .rst(rst), .sts_set(sts_set), .sts_live(sts_live),
    .clr_en(wr && (sel == RG_CLR)), .clr_bits(bus_wdata[STICKY_W-1:0]),
    .mask_we(mask_we), .mask_wdata(bus_wdata[STS_W-1:0]),
    .status(status_w), .masks(mask_w), .irq(irq));

  mmc_fifo_gate #(.LEN_W(LEN_W)) u_gate (
    .clk(clk), .rst(rst), .load(dctl_go), .len(data_len),
    .access(fifo_acc), .cnt(host_cnt), .open(gate_open));

  assign fifo_push  = fifo_acc && bus_write && gate_open;
  assign fifo_pop   = fifo_acc && !bus_write && gate_open;
  assign fifo_wdata = bus_wdata;
  assign resp_idx   = 2'(bus_addr[5:2] - 4'd5);

  always_comb begin
    case (sel)
      RG_PWR:  rd_mux = DW'(pwr_ctl);
      RG_CLK:  rd_mux = DW'(clk_ctl);
      RG_ARG:  rd_mux = cmd_arg;
      RG_CMD:  rd_mux = cmd_word;
      RG_RCMD: rd_mux = DW'(rcmd_q);
      RG_RESP: rd_mux = resp_q[resp_idx];
      RG_TMR:  rd_mux = data_timer;
      RG_LEN:  rd_mux = DW'(data_len);
      RG_DCTL: rd_mux = DW'(data_ctl);
      RG_DCNT: rd_mux = DW'(data_count);
      RG_STAT: rd_mux = DW'(status_w);
      RG_MSK:  rd_mux = DW'(mask_w[bus_addr[6]]);
      RG_FCNT: rd_mux = DW'(host_cnt);
      RG_FIFO: rd_mux = gate_open ? fifo_rdata : '0;
      RG_ID:   rd_mux = DW'(id_byte(bus_addr[4:2]));
      default: rd_mux = '0;
    endcase
  end

  // Clock setting survives reset by design.
  always_ff @(posedge clk) begin
    if (wr && sel == RG_CLK) clk_ctl <= bus_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_ctl <= '0; cmd_arg <= '0; cmd_word <= '0; data_timer <= '0;
      data_len <= '0; data_ctl <= '0; rcmd_q <= '0;
      bus_rdata <= '0; bus_err <= 1'b0; cmd_start <= 1'b0; data_start <= 1'b0;
      for (int i = 0; i < 4; i++) resp_q[i] <= '0;
    end else begin
      bus_err    <= bus_valid && !legal;
      cmd_start  <= wr && (sel == RG_CMD) && bus_wdata[CMD_GO_BIT];
      data_start <= dctl_go;
      if (bus_valid && !bus_write) bus_rdata <= legal ? rd_mux : '0;
      if (wr) begin
        case (sel)
          RG_PWR:  pwr_ctl    <= bus_wdata[7:0];
          RG_ARG:  cmd_arg    <= bus_wdata;
          RG_CMD:  cmd_word   <= bus_wdata & ~(DW'(1) << CMD_GO_BIT);
          RG_TMR:  data_timer <= bus_wdata;
          RG_LEN:  data_len   <= bus_wdata[LEN_W-1:0];
          RG_DCTL: data_ctl   <= bus_wdata[7:0];
          default: ;
        endcase
      end
      if (resp_load) begin
        rcmd_q <= resp_cmd;
        for (int i = 0; i < 4; i++) resp_q[i] <= resp_data[DW*i +: DW];
      end
    end
  end
endmodule

// File: rtl/mmc_host_regs_chk.sv
module mmc_host_regs_chk #(
  parameter int STICKY_W = 11,
  parameter int STS_W    = 22,
  parameter int CNT_W    = 15,
  parameter int NUM_IRQ  = 2
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_valid,
  input logic                          bus_write,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic                          bus_err,
  input logic                          legal,
  input logic                          cmd_start,
  input logic                          fifo_push,
  input logic                          fifo_pop,
  input logic [NUM_IRQ-1:0]            irq,
  input logic [STS_W-1:0]              status_w,
  input logic [NUM_IRQ-1:0][STS_W-1:0] mask_w,
  input logic [CNT_W-1:0]              host_cnt,
  input logic [STICKY_W-1:0]           sts_set
);
  p_irq0_mask_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq[0] == |($past(status_w & mask_w[0])));
  p_irq1_mask_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq[1] == |($past(status_w & mask_w[1])));
  p_pop_gated_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> host_cnt != '0);
  p_push_gated_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> host_cnt != '0);
  p_pop_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop || fifo_push) |=> host_cnt == $past(host_cnt) - 1'b1);
  p_bad_read_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && !legal) |=> bus_err && bus_rdata == 32'd0);
  p_cmd_start_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_start |-> $past(bus_valid && bus_write && bus_wdata[10]));
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write) && sts_set == '0 |=>
      status_w[STICKY_W-1:0] == $past(status_w[STICKY_W-1:0]));
endmodule

bind mmc_host_regs mmc_host_regs_chk #(
  .STICKY_W(STICKY_W), .STS_W(STS_W), .CNT_W(CNT_W), .NUM_IRQ(mmc_regs_pkg::NUM_IRQ)
) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .legal(legal),
  .cmd_start(cmd_start), .fifo_push(fifo_push), .fifo_pop(fifo_pop), .irq(irq),
  .status_w(status_w), .mask_w(mask_w), .host_cnt(host_cnt), .sts_set(sts_set)
);

// File: tb/tb_mmc_host_regs.sv
module tb_mmc_host_regs;
  localparam int CLK_P = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, fifo_rdata = '0;
  logic bus_err, cmd_start, data_start, fifo_push, fifo_pop;
  logic [7:0] pwr_ctl, clk_ctl, data_ctl;
  logic [31:0] cmd_arg, cmd_word, data_timer, fifo_wdata;
  logic [15:0] data_len, data_count = '0;
  logic resp_load = 0;
  logic [5:0] resp_cmd = '0;
  logic [127:0] resp_data = '0;
  logic [10:0] sts_set = '0, sts_live = '0;
  logic [1:0] irq;
  int n_chk = 0, n_fail = 0;
  logic seen_err, seen_cs, seen_ds, seen_push, seen_pop;
  logic [31:0] rv;

  mmc_host_regs dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(logic w, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d;
    #1; seen_push = fifo_push; seen_pop = fifo_pop;
    @(posedge clk); #1;
    seen_err = bus_err; seen_cs = cmd_start; seen_ds = data_start; rv = bus_rdata;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d); access(1'b1, a, d); endtask
  task automatic rdx(logic [11:0] a); access(1'b0, a, 32'h0); endtask

  task automatic t_reset;
    rdx(12'h000); chk("R1 power", rv, 0);
    rdx(12'h008); chk("R1 arg", rv, 0);
    rdx(12'h034); chk("R1 status", rv, 0);
    rdx(12'h03C); chk("R1 mask0", rv, 0);
    rdx(12'h048); chk("R1 fifo count", rv, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regs;
    wr(12'h000, 32'h1234); rdx(12'h000); chk("R2 power", rv, 32'h34);
    wr(12'h004, 32'hABCD); rdx(12'h004); chk("R2 clock", rv, 32'hCD);
    wr(12'h008, 32'hDEADBEEF); rdx(12'h008); chk("R2 arg", rv, 32'hDEADBEEF);
    wr(12'h024, 32'h89ABCDEF); rdx(12'h024); chk("R2 timer", rv, 32'h89ABCDEF);
    wr(12'h028, 32'h12345); rdx(12'h028); chk("R2 length", rv, 32'h2345);
    wr(12'h02C, 32'h1F0); rdx(12'h02C); chk("R2 data ctl", rv, 32'hF0);
    chk("R2 no start", 32'(seen_ds), 0);
    wr(12'h040, 32'hFFFFFFFF); rdx(12'h040); chk("R2 mask1", rv, 32'h3FFFFF);
    wr(12'h040, 32'h0);
    wr(12'h000, 32'h55);
    chk("R3 rdata held across write", bus_rdata, 32'h3FFFFF);
  endtask

  task automatic t_cmd;
    wr(12'h00C, 32'h445); chk("R7 start pulse", 32'(seen_cs), 1);
    @(posedge clk); #1; chk("R7 one cycle", 32'(cmd_start), 0);
    rdx(12'h00C); chk("R7 readback", rv, 32'h45);
    wr(12'h00C, 32'h41); chk("R7 no start", 32'(seen_cs), 0);
  endtask

  task automatic t_status;
    @(negedge clk); sts_set = 11'h005; sts_live = 11'h003;
    @(negedge clk); sts_set = '0;
    repeat (3) @(posedge clk);
    rdx(12'h034); chk("R5 sticky and live", rv, 32'h1805);
    wr(12'h038, 32'hFFFFF804); rdx(12'h034); chk("R4 clear low only", rv, 32'h1801);
    @(negedge clk); sts_set = 11'h002; bus_valid = 1; bus_write = 1;
    bus_addr = 12'h038; bus_wdata = 32'h2;
    @(negedge clk); sts_set = '0; bus_valid = 0; bus_write = 0;
    rdx(12'h034); chk("R4 set beats clear", rv, 32'h1803);
    wr(12'h038, 32'h2);
  endtask

  task automatic t_irq;
    wr(12'h03C, 32'h1); wr(12'h040, 32'h800);
    @(posedge clk); #1; chk("R6 both lines", 32'(irq), 2'b11);
    wr(12'h038, 32'h1);
    @(posedge clk); #1; chk("R6 line0 drop", 32'(irq), 2'b10);
    wr(12'h040, 32'h0);
    @(posedge clk); #1; chk("R6 mask off", 32'(irq), 2'b00);
  endtask

  task automatic t_fifo;
    wr(12'h028, 32'd10); wr(12'h02C, 32'h3);
    chk("R8 data start", 32'(seen_ds), 1);
    rdx(12'h048); chk("R8 count", rv, 3);
    wr(12'h084, 32'h11223344);
    chk("R9 push strobe", 32'(seen_push), 1);
    rdx(12'h048); chk("R9 count dec", rv, 2);
    fifo_rdata = 32'hCAFEF00D;
    rdx(12'h0BC); chk("R9 pop strobe", 32'(seen_pop), 1);
    chk("R9 pop data", rv, 32'hCAFEF00D);
    rdx(12'h080); rdx(12'h048); chk("R9 count zero", rv, 0);
    wr(12'h028, 32'hFFFF); wr(12'h02C, 32'h1);
    rdx(12'h048); chk("R8 max length", rv, 32'h4000);
    wr(12'h028, 32'h0); wr(12'h02C, 32'h1);
    rdx(12'h048); chk("R8 zero length", rv, 0);
  endtask

  task automatic t_fifo_zero;
    wr(12'h090, 32'h5); chk("R10 no push", 32'(seen_push), 0);
    rdx(12'h090); chk("R10 no pop", 32'(seen_pop), 0);
    chk("R10 read zero", rv, 0);
    rdx(12'h048); chk("R10 count stays", rv, 0);
  endtask

  task automatic t_id;
    logic [7:0] exp [8] = '{8'h81, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      rdx(12'hFE0 + 12'(4*i)); chk("R11 id byte", rv, 32'(exp[i]));
    end
  endtask

  task automatic t_bad;
    rdx(12'h044); chk("R12 err undefined", 32'(seen_err), 1); chk("R12 zero", rv, 0);
    @(posedge clk); #1; chk("R12 err pulse", 32'(bus_err), 0);
    rdx(12'h038); chk("R12 clear read", 32'(seen_err), 1);
    wr(12'h034, 32'hFFFFFFFF); chk("R12 ro write", 32'(seen_err), 1);
    rdx(12'h034); chk("R12 status kept", rv, 32'h1800);
    wr(12'h002, 32'hFF); chk("R12 misaligned", 32'(seen_err), 1);
    rdx(12'h000); chk("R12 power kept", rv, 32'h55);
  endtask

  task automatic t_resp;
    @(negedge clk); resp_load = 1; resp_cmd = 6'h2A;
    resp_data = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
    data_count = 16'h0077;
    @(negedge clk); resp_load = 0;
    rdx(12'h010); chk("R13 resp cmd", rv, 32'h2A);
    rdx(12'h014); chk("R13 word0", rv, 32'h11111111);
    rdx(12'h020); chk("R13 word3", rv, 32'h44444444);
    rdx(12'h030); chk("R13 data count", rv, 32'h77);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset; t_regs;
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rdx(12'h004); chk("R1 clock kept", rv, 32'hCD);
    rdx(12'h000); chk("R1 power cleared", rv, 0);
    wr(12'h000, 32'h55);
    t_cmd; t_status; t_irq; t_fifo; t_fifo_zero; t_id; t_bad; t_resp;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule